// File: doc/BRIEF.md
# Palette-Indexed Parallel Pattern Shifter

This block drives an 8-bit parallel output bus from compact frames. Each frame carries a 32-bit word of pixel indices and a palette of four 8-bit output values. The block consumes indices from the low end of the word, one pixel per programmable number of enabled clock ticks, and places the selected palette byte on the bus. A typical use is generating the clock, data and select lines of several serial devices at once. Because each frame brings its own palette, the set of output combinations can change from frame to frame.

Frames come in through a valid/ready port into a single holding register. A held frame replaces the running one at the end of that frame's last pixel tick. If nothing is held at that point, the running frame starts again. Every counter and the shift register advance only on cycles where `pix_en` is high, so gating that input slows the whole pattern. The controller has two states. `ST_IDLE` is the state after reset, with the bus at zero. `ST_RUN` is the streaming state. Three transitions are named: START (`ST_IDLE` to `ST_RUN` on the first enabled tick with a frame held), SWAP (frame boundary in `ST_RUN` with a frame held), and REPEAT (frame boundary in `ST_RUN` with nothing held).

Top module: `pps_pattern_shifter`

## Requirements
- R1: After reset `out_bus` is 0x00 and `ld_ready` is 1; `out_bus` stays 0x00 until the first frame has started.
- R2: A frame (`ld_pixels`, `ld_palette`) is taken on a clock edge where `ld_valid` and `ld_ready` are both 1. `ld_ready` is 0 from the next cycle while that frame is held, and returns to 1 in the cycle after the held frame is moved into use.
- R3: With `cfg_four`=1 pixel k is `ld_pixels[2k+1:2k]` (k from 0, least significant end first). `out_bus` equals palette entry i, which is `ld_palette[8i+7:8i]`.
- R4: With `cfg_four`=0 pixel k is bit k of the word and selects entry 0 or entry 1; palette entries 2 and 3 have no effect on the bus.
- R5: Each pixel lasts `cfg_cpp` enabled ticks; a value of 0 behaves as 1.
- R6: A frame lasts `cfg_cpf` enabled ticks and may end part-way through a pixel; pixel 0 of the next frame follows. A value of 0 behaves as 1.
- R7: A held frame and its palette take effect exactly on the first tick after the running frame's last tick, and never earlier.
- R8: At a frame boundary with no frame held, the running frame's word and palette are replayed from pixel 0.
- R9: On cycles with `pix_en`=0 nothing advances: the bus holds its value, and a held frame is not started from `ST_IDLE`.
- R10: The first frame starts on the first enabled edge after the edge that accepted it. Its pixel 0 is on the bus in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock tick enable |
| cfg_four | input | 1 | 1: 2-bit pixels, four entries; 0: 1-bit pixels, two entries |
| cfg_cpp | input | 8 | Enabled ticks per pixel |
| cfg_cpf | input | 10 | Enabled ticks per frame |
| ld_valid | input | 1 | Frame offered |
| ld_ready | output | 1 | Holding register empty |
| ld_pixels | input | 32 | Pixel index word |
| ld_palette | input | 32 | Four 8-bit palette entries, entry i at bits 8i+7:8i |
| out_bus | output | 8 | Parallel pattern output |

## Verification
A wrong pixel counter shows up on the bus within one pixel period, as a byte held too long or replaced too soon. A wrong frame counter or holding-register state appears at the next frame boundary, as a swap one tick early or late or a missed replay. The bench therefore compares the bus on every cycle of two full frames for each configuration, so any such slip is seen within `cfg_cpf` ticks. A wrong idle/run state is visible immediately, because in idle the bus is forced to zero.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int PAL_N = 4;
    localparam int IDX_W = $clog2(PAL_N);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pps_state_t;

    typedef enum logic {
        MODE_TWO  = 1'b0,
        MODE_FOUR = 1'b1
    } pps_mode_t;
endpackage

// File: rtl/pps_pending.sv
module pps_pending #(
    parameter int WORD_W = 32,
    parameter int PAL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [PAL_W-1:0]  in_pal,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] held_word,
    output logic [PAL_W-1:0]  held_pal
);
    logic accept;

    assign in_ready = !full;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            held_word <= '0;
            held_pal  <= '0;
        end else begin
            if (accept) begin
                full      <= 1'b1;
                held_word <= in_word;
                held_pal  <= in_pal;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int CPP_W = 8,
    parameter int CPF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CPP_W-1:0] cfg_cpp,
    input  logic [CPF_W-1:0] cfg_cpf,
    output logic             pix_last,
    output logic             frm_last
);
    logic [CPP_W-1:0] pix_cnt;
    logic [CPF_W-1:0] frm_cnt;
    logic [CPP_W-1:0] cpp_eff;
    logic [CPF_W-1:0] cpf_eff;

    assign cpp_eff  = (cfg_cpp == '0) ? CPP_W'(1) : cfg_cpp;
    assign cpf_eff  = (cfg_cpf == '0) ? CPF_W'(1) : cfg_cpf;
    assign pix_last = (pix_cnt == cpp_eff - CPP_W'(1));
    assign frm_last = (frm_cnt == cpf_eff - CPF_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pix_cnt <= '0;
            frm_cnt <= '0;
        end else if (tick) begin
            if (frm_last) begin
                pix_cnt <= '0;
                frm_cnt <= '0;
            end else begin
                frm_cnt <= frm_cnt + CPF_W'(1);
                pix_cnt <= pix_last ? '0 : pix_cnt + CPP_W'(1);
            end
        end
    end
endmodule

// File: rtl/pps_lookup.sv
module pps_lookup
    import pps_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic [PAL_N*OUT_W-1:0] pal,
    input  logic [IDX_W-1:0]       idx,
    output logic [OUT_W-1:0]       value
);
    logic [OUT_W-1:0] entry [PAL_N];

    for (genvar g = 0; g < PAL_N; g++) begin : g_entry
        assign entry[g] = pal[g*OUT_W +: OUT_W];
    end

    assign value = entry[idx];
endmodule

// File: rtl/pps_pattern_shifter.sv
module pps_pattern_shifter
    import pps_pkg::*;
#(
    parameter int OUT_W  = 8,
    parameter int WORD_W = 32,
    parameter int CPP_W  = 8,
    parameter int CPF_W  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_en,
    input  logic                   cfg_four,
    input  logic [CPP_W-1:0]       cfg_cpp,
    input  logic [CPF_W-1:0]       cfg_cpf,
    input  logic                   ld_valid,
    output logic                   ld_ready,
    input  logic [WORD_W-1:0]      ld_pixels,
    input  logic [PAL_N*OUT_W-1:0] ld_palette,
    output logic [OUT_W-1:0]       out_bus
);
    localparam int PAL_W = PAL_N * OUT_W;

    pps_state_t state_q, state_d;
    pps_mode_t  mode;

    logic              pend_full;
    logic [WORD_W-1:0] pend_word;
    logic [PAL_W-1:0]  pend_pal;
    logic              take;
    logic              start;
    logic              boundary;
    logic              pix_last;
    logic              frm_last;
    logic              run_tick;
    logic              running;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] act_word;
    logic [PAL_W-1:0]  act_pal;
    logic [IDX_W-1:0]  idx;
    logic [OUT_W-1:0]  lut_val;

    assign mode     = pps_mode_t'(cfg_four);
    assign running  = (state_q == ST_RUN);
    assign run_tick = running && pix_en;
    assign start    = (state_q == ST_IDLE) && pix_en && pend_full;
    assign boundary = run_tick && frm_last;
    assign take     = start || (boundary && pend_full);

    pps_pending #(.WORD_W(WORD_W), .PAL_W(PAL_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (ld_valid),
        .in_ready (ld_ready),
        .in_word  (ld_pixels),
        .in_pal   (ld_palette),
        .take     (take),
        .full     (pend_full),
        .held_word(pend_word),
        .held_pal (pend_pal)
    );

    pps_timer #(.CPP_W(CPP_W), .CPF_W(CPF_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (run_tick),
        .restart (start),
        .cfg_cpp (cfg_cpp),
        .cfg_cpf (cfg_cpf),
        .pix_last(pix_last),
        .frm_last(frm_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: START, SWAP, REPEAT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Pixel word and palette datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            act_word <= '0;
            act_pal  <= '0;
        end else if (take) begin
            shift_q  <= pend_word;
            act_word <= pend_word;
            act_pal  <= pend_pal;
        end else if (boundary) begin
            shift_q <= act_word;
        end else if (run_tick && pix_last) begin
            shift_q <= (mode == MODE_FOUR) ? (shift_q >> 2) : (shift_q >> 1);
        end
    end

    assign idx = (mode == MODE_FOUR) ? shift_q[IDX_W-1:0]
                                     : {{(IDX_W-1){1'b0}}, shift_q[0]};

    pps_lookup #(.OUT_W(OUT_W)) u_lut (
        .pal  (act_pal),
        .idx  (idx),
        .value(lut_val)
    );

    // Output process
    always_comb begin
        unique case (state_q)
            ST_RUN:  out_bus = lut_val;
            default: out_bus = '0;
        endcase
    end
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic             cfg_four,
    input logic             ld_valid,
    input logic             ld_ready,
    input logic             running,
    input logic             frm_last,
    input logic [OUT_W-1:0] out_bus
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> out_bus == '0); // R1

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_ready |=> !ld_ready); // R2

    AST_HELD_UNTIL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ready && !(pix_en && (!running || frm_last)) |=> !ld_ready); // R7

    AST_STAY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(out_bus) || !$stable(cfg_four) || $rose(running)); // R9

    AST_NO_START_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !pix_en |=> !running); // R9
endmodule

bind pps_pattern_shifter pps_checker #(.OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .cfg_four(cfg_four),
    .ld_valid(ld_valid),
    .ld_ready(ld_ready),
    .running (running),
    .frm_last(frm_last),
    .out_bus (out_bus)
);

// File: tb/pps_pattern_shifter_tb.sv
`timescale 1ns/1ps
module pps_pattern_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        cfg_four = 1'b0;
    logic [7:0]  cfg_cpp = 8'd1;
    logic [9:0]  cfg_cpf = 10'd1;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [31:0] ld_pixels = '0;
    logic [31:0] ld_palette = '0;
    logic [7:0]  out_bus;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pps_pattern_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_four(cfg_four),
        .cfg_cpp(cfg_cpp), .cfg_cpf(cfg_cpf), .ld_valid(ld_valid),
        .ld_ready(ld_ready), .ld_pixels(ld_pixels), .ld_palette(ld_palette),
        .out_bus(out_bus)
    );

    typedef struct packed {
        logic        four;
        logic [7:0]  cpp;
        logic [9:0]  cpf;
        logic [31:0] word;
        logic [31:0] pal;
    } vec_t;

    // mode, ticks/pixel, ticks/frame, pixel word, palette
    localparam vec_t VECS [5] = '{
        '{1'b1, 8'd1, 10'd16, 32'hE4E4_1B1B, 32'h8844_2211},  // R3
        '{1'b0, 8'd1, 10'd32, 32'hA5C3_0F96, 32'h0000_C33C},  // R4
        '{1'b1, 8'd3, 10'd12, 32'h0000_00D8, 32'h0804_0201},  // R5
        '{1'b0, 8'd2, 10'd7,  32'h0000_000B, 32'hDEAD_55AA},  // R4 R6
        '{1'b1, 8'd0, 10'd5,  32'h0000_0393, 32'hF00F_A55A}   // R5 R6
    };

    function automatic logic [7:0] exp_out(vec_t v, int t);
        int cpp;
        int cpf;
        int p;
        int idx;
        cpp = (v.cpp == 0) ? 1 : int'(v.cpp);
        cpf = (v.cpf == 0) ? 1 : int'(v.cpf);
        p   = (t % cpf) / cpp;
        idx = v.four ? int'((v.word >> (2 * p)) & 32'd3) : int'((v.word >> p) & 32'd1);
        return v.pal[8 * idx +: 8];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        ld_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge: offers a frame for one cycle, returns at the next negedge
    task automatic offer(logic [31:0] w, logic [31:0] p);
        ld_valid   = 1'b1;
        ld_pixels  = w;
        ld_palette = p;
        @(negedge clk);
        ld_valid   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Reset state
        do_reset();
        chk("R1 out after reset", out_bus, 8'h00);
        chk("R1 ready after reset", ld_ready, 1'b1);

        // Table walk
        foreach (VECS[i]) begin
            cfg_four = VECS[i].four;
            cfg_cpp  = VECS[i].cpp;
            cfg_cpf  = VECS[i].cpf;
            pix_en   = 1'b1;
            do_reset();
            offer(VECS[i].word, VECS[i].pal);
            chk("R2 ready low while held", ld_ready, 1'b0);
            chk("R10 bus zero before start", out_bus, 8'h00);
            @(negedge clk);
            chk("R2 ready back after start", ld_ready, 1'b1);
            for (int t = 0; t < 2 * int'((VECS[i].cpf == 0) ? 10'd1 : VECS[i].cpf); t++) begin
                chk($sformatf("R3/R4/R5/R6/R8 vec %0d t %0d", i, t), out_bus, exp_out(VECS[i], t));
                @(negedge clk);
            end
        end

        // R9 R10: held frame does not start without ticks
        cfg_four = 1'b1; cfg_cpp = 8'd1; cfg_cpf = 10'd4;
        pix_en = 1'b0;
        do_reset();
        offer(32'h0000_00E4, 32'h4030_2010);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no start while disabled", out_bus, 8'h00);
        end
        pix_en = 1'b1;
        @(negedge clk);
        chk("R10 pixel 0 after first tick", out_bus, 8'h10);

        // R7: swap exactly at the boundary
        offer(32'h0000_001B, 32'h0403_0201);   // t=1 now
        chk("R2 ready low with frame held", ld_ready, 1'b0);
        chk("R7 old frame t1", out_bus, 8'h20);
        @(negedge clk);
        chk("R7 old frame t2", out_bus, 8'h30);
        @(negedge clk);
        chk("R7 old frame t3", out_bus, 8'h40);
        chk("R7 still held before edge", ld_ready, 1'b0);
        @(negedge clk);
        chk("R7 new frame at boundary", out_bus, 8'h04);
        chk("R2 ready after swap", ld_ready, 1'b1);
        @(negedge clk);
        chk("R7 new frame pixel 1", out_bus, 8'h03);
        repeat (3) @(negedge clk);
        chk("R8 replay pixel 0", out_bus, 8'h04);
        @(negedge clk);
        chk("R8 replay pixel 1", out_bus, 8'h03);

        // R9: gating holds the bus
        pix_en = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R9 hold while disabled", out_bus, 8'h03);
        end
        pix_en = 1'b1;
        @(negedge clk);
        chk("R9 resume next pixel", out_bus, 8'h02);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule